// File: doc/BRIEF.md
# Digital Closed-Loop Supply Trim Controller

This block holds one supply rail at a target voltage by nudging a trim DAC code one step at a time. It keeps the most recent digitized monitor sample. At the end of each update interval it compares that sample with a setpoint, which gives one of three outcomes: raise, hold or lower. A polarity input sets which way the code moves for each outcome, and the result is applied to the DAC code register. The code saturates at its two ends and never wraps.

A 2-bit rate select picks one of four interval lengths. Each length is a tick count parameter that is derived from the system clock. The defaults assume a 200 MHz clock and give 432 µs, 1.06 ms, 8.74 ms and 16.9 ms. An active-low enable starts trimming. When the enable is released, the interval already under way runs to its end and applies its step. The code then freezes for as long as the enable stays high. When the enable is asserted again, trimming restarts from the frozen code.

Each instance serves exactly one monitor input and one trim output.

Top module: `trim_loop_ctrl`

## Requirements
- R1: While reset `rstN` is low, `dacCode` loads `initCode`. After reset the controller stays idle, and `dacCode` does not change while `trimEnN` is high.
- R2: With `trimEnN` low, an update occurs every N cycles. N is `TICKS0`, `TICKS1`, `TICKS2` or `TICKS3` for `rateSel` = 2'b00, 2'b01, 2'b10 or 2'b11. The first update comes N cycles after the clock edge at which `trimEnN` is first seen low.
- R3: A sample below `setpoint - DEADBAND` is a "low" result. A sample above `setpoint + DEADBAND` is a "high" result. A sample anywhere inside that window, including one equal to `setpoint`, leaves the code unchanged.
- R4: With `polarity` = 0, a low result adds one to the code and a high result subtracts one. With `polarity` = 1, a low result subtracts one and a high result adds one.
- R5: The code stays at all-ones when a step would raise it. It stays at zero when a step would lower it.
- R6: When `trimEnN` goes high in the middle of an interval, that interval still finishes and applies its update. No later update follows.
- R7: After a pause, the code holds indefinitely. When `trimEnN` returns low, trimming continues from the held code, and the first step comes a full interval later.
- R8: Updates use the latest sample taken with `adcValid`. No step is applied until at least one sample has been taken since reset.
- R9: The code changes by at most one LSB per update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initCode | input | CODE_W | DAC code loaded during reset |
| adcSample | input | ADC_W | Digitized monitor voltage |
| adcValid | input | 1 | Captures `adcSample` when high |
| setpoint | input | ADC_W | Target monitor value |
| polarity | input | 1 | 0: a low result raises the code; 1: a low result lowers it |
| rateSel | input | 2 | Update interval select |
| trimEnN | input | 1 | Active-low trim enable (pause when high) |
| dacCode | output | CODE_W | Trim DAC code register |

## Verification
The bench measures the gap between successive code steps at every rate select. It also measures the latency of the first step after enable, which catches an off-by-one interval timer or a timer that is not restarted. It releases the enable partway through an interval and expects exactly one more step. A design that stops at once, or keeps trimming, fails that count. It probes both edges of the deadband and both polarities, so a flipped comparison or an inverted direction shows up as a wrong step. It drives the code into both ends to catch wraparound, and it runs with no sample captured to catch a design that trims from a reset-value sample.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } trim_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic apply;   // end of interval: apply one compare step
    logic active;  // an interval is in progress
  } trim_strobe_t;

endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int unsigned TICKS0 = 86400,
  parameter int unsigned TICKS1 = 212000,
  parameter int unsigned TICKS2 = 1748000,
  parameter int unsigned TICKS3 = 3380000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   rateSel,
  input  logic         trimEnN,
  output trim_strobe_t strobes
);

  localparam int unsigned MAX01 = (TICKS0 > TICKS1) ? TICKS0 : TICKS1;
  localparam int unsigned MAX23 = (TICKS2 > TICKS3) ? TICKS2 : TICKS3;
  localparam int unsigned MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(MAXT + 1);

  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(TICKS0 - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(TICKS1 - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(TICKS2 - 1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(TICKS3 - 1);

  trim_state_t      stateQ;
  logic [CNT_W-1:0] timerQ;
  logic [CNT_W-1:0] limit;
  logic             terminal;

  always_comb begin
    case (rateSel)
      2'b00:   limit = LIM0;
      2'b01:   limit = LIM1;
      2'b10:   limit = LIM2;
      default: limit = LIM3;
    endcase
  end

  // >= so that a rate change mid-interval cannot overshoot the count
  assign terminal = (timerQ >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      timerQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          timerQ <= '0;
          if (!trimEnN) stateQ <= ST_RUN;
        end
        default: begin
          if (terminal) begin
            timerQ <= '0;
            if (trimEnN) stateQ <= ST_IDLE;  // pause only at interval end
          end else begin
            timerQ <= timerQ + 1'b1;
          end
        end
      endcase
    end
  end

  assign strobes.apply  = (stateQ == ST_RUN) && terminal;
  assign strobes.active = (stateQ == ST_RUN);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && trimEnN) |=> (stateQ == ST_IDLE));

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && !terminal) |=> (stateQ == ST_RUN));

  // R2
  single_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.apply |=> !strobes.apply);

endmodule

// File: rtl/trim_datapath.sv
module trim_datapath
  import trim_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned DEADBAND = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] initCode,
  input  logic [ADC_W-1:0]  adcSample,
  input  logic              adcValid,
  input  logic [ADC_W-1:0]  setpoint,
  input  logic              polarity,
  input  trim_strobe_t      strobes,
  output logic [CODE_W-1:0] dacCode
);

  localparam int unsigned EXT_W = ADC_W + 2;
  localparam logic [EXT_W-1:0] DB_V = EXT_W'(DEADBAND);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [ADC_W-1:0]  sampleQ;
  logic              haveSampleQ;
  logic [CODE_W-1:0] codeQ;
  logic [EXT_W-1:0]  sampleExt, setExt;
  logic              isLow, isHigh, stepUp, stepDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ     <= '0;
      haveSampleQ <= 1'b0;
    end else if (adcValid) begin
      sampleQ     <= adcSample;
      haveSampleQ <= 1'b1;
    end
  end

  // three-state compare with a symmetric no-change window
  assign sampleExt = EXT_W'(sampleQ);
  assign setExt    = EXT_W'(setpoint);
  assign isLow     = (sampleExt + DB_V) < setExt;
  assign isHigh    = sampleExt > (setExt + DB_V);

  assign stepUp   = (isLow && !polarity) || (isHigh && polarity);
  assign stepDown = (isLow && polarity) || (isHigh && !polarity);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= initCode;
    end else if (strobes.apply && haveSampleQ) begin
      if (stepUp && codeQ != CODE_MAX)
        codeQ <= codeQ + 1'b1;
      else if (stepDown && codeQ != CODE_MIN)
        codeQ <= codeQ - 1'b1;
    end
  end

  assign dacCode = codeQ;

  // R9
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ != $past(codeQ)) |->
      (codeQ == $past(codeQ) + CODE_W'(1) || codeQ == $past(codeQ) - CODE_W'(1)));

  // R5
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ == CODE_MAX) |=> (codeQ != CODE_MIN));

  // R5
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ == CODE_MIN) |=> (codeQ != CODE_MAX));

  // R8
  no_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !haveSampleQ |=> $stable(codeQ));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |=> $stable(codeQ));

endmodule

// File: rtl/trim_loop_ctrl.sv
module trim_loop_ctrl
  import trim_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned DEADBAND = 0,
  parameter int unsigned TICKS0   = 86400,
  parameter int unsigned TICKS1   = 212000,
  parameter int unsigned TICKS2   = 1748000,
  parameter int unsigned TICKS3   = 3380000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] initCode,
  input  logic [ADC_W-1:0]  adcSample,
  input  logic              adcValid,
  input  logic [ADC_W-1:0]  setpoint,
  input  logic              polarity,
  input  logic [1:0]        rateSel,
  input  logic              trimEnN,
  output logic [CODE_W-1:0] dacCode
);

  trim_strobe_t strobes;

  trim_ctrl #(
    .TICKS0(TICKS0), .TICKS1(TICKS1), .TICKS2(TICKS2), .TICKS3(TICKS3)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rateSel (rateSel),
    .trimEnN (trimEnN),
    .strobes (strobes)
  );

  trim_datapath #(
    .CODE_W(CODE_W), .ADC_W(ADC_W), .DEADBAND(DEADBAND)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .initCode  (initCode),
    .adcSample (adcSample),
    .adcValid  (adcValid),
    .setpoint  (setpoint),
    .polarity  (polarity),
    .strobes   (strobes),
    .dacCode   (dacCode)
  );

endmodule

// File: tb/test_trim_loop_ctrl.sv
module test_trim_loop_ctrl;

  localparam int T0 = 6;
  localparam int T1 = 9;
  localparam int T2 = 13;
  localparam int T3 = 20;
  localparam int DB = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] initCode;
  logic [9:0] adcSample;
  logic       adcValid;
  logic [9:0] setpoint;
  logic       polarity;
  logic [1:0] rateSel;
  logic       trimEnN;
  logic [7:0] dacCode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  trim_loop_ctrl #(
    .CODE_W(8), .ADC_W(10), .DEADBAND(DB),
    .TICKS0(T0), .TICKS1(T1), .TICKS2(T2), .TICKS3(T3)
  ) i_trim_loop_ctrl (
    .clk(clk), .rstN(rstN), .initCode(initCode), .adcSample(adcSample),
    .adcValid(adcValid), .setpoint(setpoint), .polarity(polarity),
    .rateSel(rateSel), .trimEnN(trimEnN), .dacCode(dacCode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles until dacCode changes (capped at limit)
  task automatic waitStep(input int limit, output int n);
    logic [7:0] prev;
    prev = dacCode;
    n = 0;
    while (dacCode == prev && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic loadSample(input int v);
    adcSample = 10'(v);
    adcValid  = 1'b1;
    @(negedge clk);
    adcValid  = 1'b0;
  endtask

  task automatic resetDut(input int code);
    @(negedge clk);
    rstN = 1'b0; initCode = 8'(code); trimEnN = 1'b1; adcValid = 1'b0;
    adcSample = '0; setpoint = 10'd500; polarity = 1'b0; rateSel = 2'b00;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    resetDut(77);
    check("R1 reset code", dacCode, 77);
    loadSample(100);
    idle(4 * T3);
    check("R1 idle while enable high", dacCode, 77);
  endtask

  task automatic testNoSample();
    int n;
    resetDut(50);
    trimEnN = 1'b0;
    idle(3 * T0);
    check("R8 no step without sample", dacCode, 50);
    loadSample(100);
    waitStep(T0 + 2, n);
    check("R8 step after first sample", dacCode, 51);
  endtask

  task automatic testRates();
    int n;
    resetDut(20);
    loadSample(100);
    trimEnN = 1'b0;
    waitStep(T0 + 3, n);
    check("R2 first update latency rate 00", n, T0 + 1);
    for (int r = 0; r < 4; r++) begin
      int exp;
      rateSel = 2'(r);
      exp = (r == 0) ? T0 : (r == 1) ? T1 : (r == 2) ? T2 : T3;
      waitStep(T3 + 2, n);
      waitStep(T3 + 2, n);
      check($sformatf("R2 interval rate %0d", r), n, exp);
    end
  endtask

  task automatic testCompare(input logic pol);
    int n;
    int base;
    resetDut(100);
    polarity = pol;
    loadSample(500 - DB);
    trimEnN = 1'b0;
    idle(3 * T0);
    check("R3 low edge of window holds", dacCode, 100);
    loadSample(500);
    idle(2 * T0);
    check("R3 equal holds", dacCode, 100);
    loadSample(500 + DB);
    idle(2 * T0);
    check("R3 high edge of window holds", dacCode, 100);
    base = dacCode;
    loadSample(500 - DB - 1);
    waitStep(T0 + 2, n);
    check(pol ? "R4 low result pol1 lowers" : "R4 low result pol0 raises",
          dacCode, pol ? base - 1 : base + 1);
    loadSample(500 + DB + 1);
    base = dacCode;
    waitStep(T0 + 2, n);
    check(pol ? "R4 high result pol1 raises" : "R4 high result pol0 lowers",
          dacCode, pol ? base + 1 : base - 1);
    waitStep(T0 + 2, n);
    check("R9 one LSB per update", dacCode, pol ? base + 2 : base - 2);
  endtask

  task automatic testSaturate();
    int n;
    resetDut(254);
    loadSample(100);
    trimEnN = 1'b0;
    waitStep(T0 + 3, n);
    check("R5 reach all-ones", dacCode, 255);
    idle(4 * T0);
    check("R5 hold at all-ones", dacCode, 255);
    resetDut(1);
    polarity = 1'b1;
    loadSample(100);
    trimEnN = 1'b0;
    waitStep(T0 + 3, n);
    check("R5 reach zero", dacCode, 0);
    idle(4 * T0);
    check("R5 hold at zero", dacCode, 0);
  endtask

  task automatic testPause();
    int n;
    int held;
    resetDut(30);
    loadSample(100);
    trimEnN = 1'b0;
    waitStep(T1 + 3, n);
    waitStep(T1 + 3, n);          // aligned on a step
    @(negedge clk);
    trimEnN = 1'b1;               // release one cycle into the interval
    held = dacCode;
    waitStep(T0 + 2, n);
    check("R6 running interval completes", n, T0 - 1);
    check("R6 final step applied", dacCode, held + 1);
    held = dacCode;
    idle(10 * T0);
    check("R7 code held while paused", dacCode, held);
    trimEnN = 1'b0;
    waitStep(T0 + 3, n);
    check("R7 resume latency", n, T0 + 1);
    check("R7 resume from held code", dacCode, held + 1);
  endtask

  initial begin
    rstN = 1'b0; initCode = '0; adcSample = '0; adcValid = 1'b0;
    setpoint = '0; polarity = 1'b0; rateSel = 2'b00; trimEnN = 1'b1;
    testReset();
    testNoSample();
    testRates();
    testCompare(1'b0);
    testCompare(1'b1);
    testSaturate();
    testPause();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule